// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power states of a small processor subsystem. It has five states: normal run, a light sleep, software standby, a settling phase that follows a wake from software standby, and hardware standby. It turns the CPU clock enable, the peripheral clock enable and the CPU halt on or off. It sends a one-cycle initialise pulse to the peripherals and drives the I/O port controls (hold, tri-state or initialise). After each return to run it raises a one-cycle wake indication.

Hardware standby is entered from an active-low pin and has priority over every other event. Software standby and sleep are both entered from a one-cycle sleep request that the CPU issues in the run state. A standby-select control bit decides which of the two is entered. Each low-power state has its own set of wake sources. After a non-maskable interrupt ends software standby, the CPU clock stays off for a programmable number of reference-clock cycles so that the oscillator can settle. The free-running block clock serves as the reference clock.

Top module: `lpm_controller`

## Requirements
- R1: After reset the block is in run. The outputs are cpuClkEn=1, periphClkEn=1, cpuHalt=0, portHold=0, portHiZ=0, portInit=0, periphInit=0 and wake=0.
- R2: When hwStbyN is sampled low in any state, the block is in hardware standby from the next cycle. The outputs are cpuClkEn=0, periphClkEn=0, cpuHalt=1, portInit=1, portHold=0 and portHiZ=0. periphInit is high in the first cycle of that standby.
- R3: Hardware standby ends only in a cycle with both hwStbyN=1 and porIn=1. The block is in run on the next cycle, and wake is high for that one cycle. No other input ends it.
- R4: A sleepReq sampled in run with stbySel=1 enters software standby. The outputs are both clock enables 0, cpuHalt=1 and one periphInit pulse. portHiZ takes the value portHiZSel had at the request and portHold takes its complement. Later changes to portHiZSel have no effect.
- R5: A sleepReq sampled in run with stbySel=0 enters sleep. The outputs are cpuClkEn=1, periphClkEn=1, cpuHalt=1, portHold=1 and portHiZ=0.
- R6: An nmi in software standby starts settling. Settling lasts exactly settleCycles+1 cycles, and its outputs match software standby without the periphInit pulse. The block then returns to run with a wake pulse.
- R7: In software standby, irq, dmaAddrErr and sleepReq have no effect.
- R8: Sleep ends on irq, nmi, dmaAddrErr or porIn. The block is in run on the next cycle with a wake pulse.
- R9: sleepReq is accepted only in run. In sleep or standby it has no effect.
- R10: Events are ranked in this order: hwStbyN low, then porIn, then nmi, then the other wake sources. If nmi and porIn arrive together in software standby, the block returns to run on the next cycle with no settling.
- R11: porIn sampled in run leaves the block in run and raises no wake pulse.
- R12: settleCycles is sampled when the nmi is accepted. Changes to it during settling have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| hwStbyN | input | 1 | Active-low hardware standby pin |
| sleepReq | input | 1 | One-cycle sleep request from the CPU |
| stbySel | input | 1 | 1 = software standby, 0 = sleep |
| portHiZSel | input | 1 | 1 = tri-state ports in software standby, 0 = hold them |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 1 | Maskable interrupt request |
| dmaAddrErr | input | 1 | DMA address-error flag |
| porIn | input | 1 | Power-on reset event |
| settleCycles | input | SETTLE_W | Oscillator settling length in cycles |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| cpuHalt | output | 1 | CPU halt |
| periphInit | output | 1 | One-cycle peripheral initialise pulse |
| portHold | output | 1 | I/O ports hold their state |
| portHiZ | output | 1 | I/O ports tri-stated |
| portInit | output | 1 | I/O ports forced to their initial state |
| wake | output | 1 | One-cycle pulse on return to run |

## Verification
Every output is decoded from the registered state or comes straight from a register. A wrong next-state choice therefore shows on the ports in the very next cycle. For example, sleep entered in place of software standby shows as a CPU clock enable that stays on, and a missed wake source shows as a halt that stays high. A wrong settle count cannot be seen until settling ends, when the clock enable returns one or more cycles early or late. The bench counts the settling cycles exactly for several lengths, including zero. A stale port-mode latch shows only as the hold/tri-state pair, and only in software standby and settling.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_SWSTBY = 3'd2,
    ST_SETTLE = 3'd3,
    ST_HWSTBY = 3'd4
  } lpmState_e;

  // Strobes from the control FSM to the datapath, valid in the cycle
  // before the matching state change takes effect.
  typedef struct packed {
    logic loadSettle;  // nmi accepted in software standby
    logic countDown;   // settling, count not yet exhausted
    logic captureHiZ;  // entering software standby from run
    logic enterStby;   // entering either standby state
    logic wakeEv;      // returning to run from a low-power state
  } lpmStrobe_t;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwStbyN,
  input  logic       sleepReq,
  input  logic       stbySel,
  input  logic       nmi,
  input  logic       irq,
  input  logic       dmaAddrErr,
  input  logic       porIn,
  input  logic       settleDone,
  output lpmState_e  stateQ,
  output lpmStrobe_t strobe
);

  lpmState_e nextState;

  // Priority: pin, then power-on reset, then nmi, then other sources.
  always_comb begin
    nextState = stateQ;
    if (!hwStbyN) begin
      nextState = ST_HWSTBY;
    end else if (stateQ == ST_HWSTBY) begin
      if (porIn) nextState = ST_RUN;
    end else if (porIn) begin
      nextState = ST_RUN;
    end else begin
      unique case (stateQ)
        ST_RUN: begin
          if (sleepReq) nextState = stbySel ? ST_SWSTBY : ST_SLEEP;
        end
        ST_SLEEP: begin
          if (nmi || irq || dmaAddrErr) nextState = ST_RUN;
        end
        ST_SWSTBY: begin
          if (nmi) nextState = ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settleDone) nextState = ST_RUN;
        end
        default: nextState = ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobe.loadSettle = (stateQ == ST_SWSTBY) && (nextState == ST_SETTLE);
    strobe.countDown  = (stateQ == ST_SETTLE) && !settleDone;
    strobe.captureHiZ = (stateQ == ST_RUN) && (nextState == ST_SWSTBY);
    strobe.enterStby  = ((nextState == ST_SWSTBY) || (nextState == ST_HWSTBY))
                        && (nextState != stateQ);
    strobe.wakeEv     = (stateQ != ST_RUN) && (nextState == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= nextState;
  end

  assert_hw_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    !hwStbyN |=> stateQ == ST_HWSTBY);

  assert_hw_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HWSTBY && !(hwStbyN && porIn)) |=> stateQ == ST_HWSTBY);

  assert_sw_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SWSTBY && hwStbyN && !porIn && !nmi) |=> stateQ == ST_SWSTBY);

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SLEEP && hwStbyN && !porIn && !nmi && !irq && !dmaAddrErr)
      |=> stateQ == ST_SLEEP);

  assert_por_nmi_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SWSTBY && hwStbyN && porIn && nmi) |=> stateQ == ST_RUN);

endmodule

// File: rtl/lpm_dp.sv
module lpm_dp
  import lpm_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  lpmState_e           stateQ,
  input  lpmStrobe_t          strobe,
  input  logic                portHiZSel,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                settleDone,
  output logic                cpuClkEn,
  output logic                periphClkEn,
  output logic                cpuHalt,
  output logic                periphInit,
  output logic                portHold,
  output logic                portHiZ,
  output logic                portInit,
  output logic                wake
);

  logic [SETTLE_W-1:0] cntQ;
  logic                hiZQ;
  logic                swSide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ       <= '0;
      hiZQ       <= 1'b0;
      periphInit <= 1'b0;
      wake       <= 1'b0;
    end else begin
      if (strobe.loadSettle)     cntQ <= settleCycles;
      else if (strobe.countDown) cntQ <= cntQ - 1'b1;
      if (strobe.captureHiZ) hiZQ <= portHiZSel;
      periphInit <= strobe.enterStby;
      wake       <= strobe.wakeEv;
    end
  end

  assign settleDone = (cntQ == '0);

  // Software standby and settling share the same port treatment.
  assign swSide = (stateQ == ST_SWSTBY) || (stateQ == ST_SETTLE);

  always_comb begin
    cpuClkEn    = (stateQ == ST_RUN) || (stateQ == ST_SLEEP);
    periphClkEn = (stateQ == ST_RUN) || (stateQ == ST_SLEEP);
    cpuHalt     = (stateQ != ST_RUN);
    portInit    = (stateQ == ST_HWSTBY);
    portHiZ     = swSide && hiZQ;
    portHold    = (stateQ == ST_SLEEP) || (swSide && !hiZQ);
  end

  assert_settle_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SETTLE && strobe.countDown && !strobe.loadSettle)
      |=> cntQ == SETTLE_W'($past(cntQ) - 1'b1));

  assert_hiz_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (swSide && !strobe.captureHiZ) |=> $stable(hiZQ));

  assert_wake_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    wake |=> !wake);

  assert_wake_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> !cpuHalt);

endmodule

// File: rtl/lpm_controller.sv
module lpm_controller
  import lpm_pkg::*;
#(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hwStbyN,
  input  logic                sleepReq,
  input  logic                stbySel,
  input  logic                portHiZSel,
  input  logic                nmi,
  input  logic                irq,
  input  logic                dmaAddrErr,
  input  logic                porIn,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic                cpuClkEn,
  output logic                periphClkEn,
  output logic                cpuHalt,
  output logic                periphInit,
  output logic                portHold,
  output logic                portHiZ,
  output logic                portInit,
  output logic                wake
);

  lpmState_e  stateQ;
  lpmStrobe_t strobe;
  logic       settleDone;

  lpm_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hwStbyN    (hwStbyN),
    .sleepReq   (sleepReq),
    .stbySel    (stbySel),
    .nmi        (nmi),
    .irq        (irq),
    .dmaAddrErr (dmaAddrErr),
    .porIn      (porIn),
    .settleDone (settleDone),
    .stateQ     (stateQ),
    .strobe     (strobe)
  );

  lpm_dp #(.SETTLE_W(SETTLE_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stateQ       (stateQ),
    .strobe       (strobe),
    .portHiZSel   (portHiZSel),
    .settleCycles (settleCycles),
    .settleDone   (settleDone),
    .cpuClkEn     (cpuClkEn),
    .periphClkEn  (periphClkEn),
    .cpuHalt      (cpuHalt),
    .periphInit   (periphInit),
    .portHold     (portHold),
    .portHiZ      (portHiZ),
    .portInit     (portInit),
    .wake         (wake)
  );

endmodule

// File: tb/test_lpm_controller.sv
module test_lpm_controller;

  localparam int SETTLE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwStbyN = 1'b1, sleepReq = 1'b0, stbySel = 1'b0, portHiZSel = 1'b0;
  logic nmi = 1'b0, irq = 1'b0, dmaAddrErr = 1'b0, porIn = 1'b0;
  logic [SETTLE_W-1:0] settleCycles = 8'd2;
  logic cpuClkEn, periphClkEn, cpuHalt, periphInit, portHold, portHiZ, portInit, wake;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lpm_controller #(.SETTLE_W(SETTLE_W)) i_lpm_controller (
    .clk(clk), .rstN(rstN), .hwStbyN(hwStbyN), .sleepReq(sleepReq),
    .stbySel(stbySel), .portHiZSel(portHiZSel), .nmi(nmi), .irq(irq),
    .dmaAddrErr(dmaAddrErr), .porIn(porIn), .settleCycles(settleCycles),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .cpuHalt(cpuHalt),
    .periphInit(periphInit), .portHold(portHold), .portHiZ(portHiZ),
    .portInit(portInit), .wake(wake)
  );

  // Output bits: cpuClkEn periphClkEn cpuHalt portHold portHiZ portInit periphInit wake
  function automatic logic [7:0] outVec();
    return {cpuClkEn, periphClkEn, cpuHalt, portHold, portHiZ, portInit, periphInit, wake};
  endfunction

  // Input bits: hwStbyN sleepReq stbySel portHiZSel nmi irq dmaAddrErr porIn
  task automatic applyIn(input logic [7:0] v);
    {hwStbyN, sleepReq, stbySel, portHiZSel, nmi, irq, dmaAddrErr, porIn} = v;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b, expected %b", req, act, exp);
    end
  endtask

  // {requirement number, inputs, expected outputs one edge later}; settleCycles = 2
  localparam int NV = 38;
  localparam logic [23:0] VEC [0:NV-1] = '{
    24'h01_80_C0,  // R1 idle run
    24'h05_C0_F0,  // R5 sleep entry
    24'h05_80_F0,  // R5 stays asleep
    24'h09_E0_F0,  // R9 request in sleep ignored
    24'h08_84_C1,  // R8 irq wakes
    24'h01_80_C0,
    24'h04_E0_32,  // R4 software standby, hold
    24'h04_90_30,  // R4 hiZ select change ignored
    24'h07_86_30,  // R7 irq and dma ignored
    24'h07_C0_30,  // R7 request ignored
    24'h06_88_30,  // R6 nmi -> settling
    24'h06_80_30,
    24'h06_80_30,
    24'h06_80_C1,  // R6 back to run, wake
    24'h06_80_C0,
    24'h04_F0_2A,  // R4 software standby, tri-state
    24'h04_80_28,
    24'h0A_89_C1,  // R10 por beats nmi, no settling
    24'h01_80_C0,
    24'h05_C0_F0,
    24'h08_82_C1,  // R8 dma error wakes
    24'h05_C0_F0,
    24'h08_88_C1,  // R8 nmi wakes
    24'h05_C0_F0,
    24'h08_81_C1,  // R8 por wakes
    24'h02_00_26,  // R2 hardware standby from run
    24'h02_00_24,
    24'h03_80_24,  // R3 pin high alone does not exit
    24'h0A_01_24,  // R10 pin low beats por
    24'h03_88_24,  // R3 nmi does not exit
    24'h03_81_C1,  // R3 pin high and por exit
    24'h0B_81_C0,  // R11 por in run, no wake
    24'h04_E0_32,
    24'h02_00_26,  // R2 hardware standby from software standby
    24'h03_81_C1,
    24'h05_C0_F0,
    24'h02_40_26,  // R2 hardware standby from sleep
    24'h03_81_C1
  };

  // Counts the cycles of settling after an nmi from software standby.
  task automatic settleRun(input logic [7:0] n, input logic [7:0] midValue);
    int lowCycles = 0;
    settleCycles = n;
    applyIn(8'hE0);
    @(posedge clk); #1;
    applyIn(8'h80);
    @(negedge clk);
    applyIn(8'h88);
    @(posedge clk); #1;
    applyIn(8'h80);
    settleCycles = midValue;  // R12 later change must be ignored
    while (!cpuClkEn && lowCycles < 400) begin
      lowCycles++;
      @(posedge clk); #1;
    end
    checks++;
    if (lowCycles != int'(n) + 1) begin
      errors++;
      $display("FAIL R6/R12: settling %0d cycles, expected %0d", lowCycles, int'(n) + 1);
    end
    check("R6 wake after settle", outVec(), 8'hC1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", outVec(), 8'hC0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      applyIn(VEC[i][15:8]);
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VEC[i][23:16], i), outVec(), VEC[i][7:0]);
      @(negedge clk);
    end
    settleRun(8'd0, 8'd9);
    settleRun(8'd5, 8'd0);
    settleRun(8'd20, 8'd1);
    // R1 reset in the middle of hardware standby returns to run
    applyIn(8'h00);
    @(negedge clk);
    rstN = 1'b0;
    applyIn(8'h80);
    #1;
    check("R1 async reset", outVec(), 8'hC0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", outVec(), 8'hC0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule